// File: doc/BRIEF.md
# PHY Test-Port Read-Modify-Write Sequencer

This block is a hardware master that changes selected bits of one internal parameter register in a serial PHY. Those registers cannot be reached directly. The only path to them is a packed test-input word that the block drives and a test-output word that it reads back. A command consists of a register address, a bit mask and a value, launched with a one-cycle start strobe. The block then runs a fixed access sequence on its own: it reads the old contents, merges in the masked value, writes the result with a pulsed write-enable, and finishes with a throw-away confirmation read. When that read completes, it pulses done.

Every change of the test-input word must be followed by two settling reads of the test-output word before the next change. Each read is a one-cycle strobe, and the response arrives on the following cycle. The sequencer therefore spends most of its time waiting on the read pacer, and a command takes a fixed number of cycles.

Top module: `phy_tp_rmw`

## Requirements
- R1: The test-input word is 14 bits wide, with data in bits 13:6, register address in bits 5:1 and write-enable in bit 0.
- R2: A command starts with a fetch. The block drives a read word (address field = command address, data field = 1, write-enable = 0) and issues three test-output reads. The low 8 bits of the third response are taken as the old register value.
- R3: After every change of the test-input word, the block issues exactly two test-output reads before the next change, plus the one extra read of the fetch and of the confirmation. A full command therefore issues 12 reads.
- R4: The read strobe is high for exactly one cycle. The response is sampled in the cycle after the strobe. Two strobes never occur in adjacent cycles, and the test-input word does not change between a strobe and its response.
- R5: The write is made of three consecutive test-input updates that all carry the same data and address. Write-enable is 0, then 1, then 0.
- R6: The written data equals (old AND NOT mask) OR (value AND mask).
- R7: After the write, the block drives the read word for the same address again and issues three reads. The results are discarded.
- R8: Done is high for exactly one cycle, two cycles after the final confirmation strobe. No read strobe is issued while idle.
- R9: A start strobe received while a command is in progress is ignored. The command inputs are captured at start, so later changes to them have no effect.
- R10: Reset is synchronous and active-high. In the cycle after reset, the test-input word is zero, and both done and the read strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe |
| reg_addr | input | 5 | Target PHY register address |
| reg_mask | input | 8 | Bits to be replaced |
| reg_value | input | 8 | New bit values (only masked bits used) |
| done | output | 1 | One-cycle completion pulse |
| tp_in | output | 14 | Test-input word to the PHY |
| tp_rd_stb | output | 1 | Test-output read strobe |
| tp_rd_data | input | OUT_W (32) | Test-output word, valid the cycle after the strobe |

## Verification
The bench builds the block with its default OUT_W of 32. It fills the 24 upper bits of every test-output response, and every non-response cycle, with random values, so a merge that used anything other than the low byte of the third fetch response would corrupt the register model. A behavioural PHY model holds 32 byte-wide registers and commits data on each rising write-enable. Because of that model, ordering errors, a missing write-enable step or a wrong merge all appear as wrong register contents or a wrong word recorded at some strobe.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;

    // Field layout of the test-input word (decoded by the PHY).
    localparam int ADDR_W  = 5;
    localparam int DAT_W   = 8;
    localparam int ADDR_LO = 1;
    localparam int DAT_LO  = ADDR_LO + ADDR_W;
    localparam int WORD_W  = DAT_LO + DAT_W;

    // Read pacing.
    localparam int SETTLE_READS = 2;
    localparam int FETCH_READS  = SETTLE_READS + 1;
    localparam int CNT_W        = $clog2(FETCH_READS + 1);

    localparam logic [DAT_W-1:0] RD_MARK = DAT_W'(1);

    typedef struct packed {
        logic [DAT_W-1:0]  dat;
        logic [ADDR_W-1:0] adr;
        logic              we;
    } tp_word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] adr;
        logic [DAT_W-1:0]  mask;
        logic [DAT_W-1:0]  val;
    } rmw_cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_WR_LO,
        PH_WR_HI,
        PH_WR_END,
        PH_CONFIRM
    } phase_e;

    typedef enum logic [1:0] {
        PC_IDLE,
        PC_STB,
        PC_WAIT
    } pace_e;

    function automatic tp_word_t read_word(input logic [ADDR_W-1:0] adr);
        tp_word_t w;
        w.dat = RD_MARK;
        w.adr = adr;
        w.we  = 1'b0;
        return w;
    endfunction

    function automatic tp_word_t data_word(input logic [ADDR_W-1:0] adr,
                                           input logic [DAT_W-1:0]  dat);
        tp_word_t w;
        w.dat = dat;
        w.adr = adr;
        w.we  = 1'b0;
        return w;
    endfunction

    function automatic logic [DAT_W-1:0] merge_bits(input logic [DAT_W-1:0] old,
                                                    input logic [DAT_W-1:0] mask,
                                                    input logic [DAT_W-1:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/phy_tp_pacer.sv
module phy_tp_pacer
    import phy_tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] reads,
    output logic             rd_stb,
    output logic             fin
);

    pace_e            state_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PC_IDLE;
            left_q  <= '0;
        end else begin
            case (state_q)
                PC_IDLE: begin
                    if (go) begin
                        state_q <= PC_STB;
                        left_q  <= reads;
                    end
                end
                PC_STB: begin
                    state_q <= PC_WAIT;
                    left_q  <= left_q - CNT_W'(1);
                end
                PC_WAIT: begin
                    state_q <= (left_q == '0) ? PC_IDLE : PC_STB;
                end
                default: state_q <= PC_IDLE;
            endcase
        end
    end

    // Strobe in one cycle, response valid in the next (WAIT).
    assign rd_stb = (state_q == PC_STB);
    assign fin    = (state_q == PC_WAIT) && (left_q == '0);

endmodule

// File: rtl/phy_tp_seq.sv
module phy_tp_seq
    import phy_tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rmw_cmd_t         cmd,
    input  logic             fin,
    input  logic [DAT_W-1:0] rd_low,
    output logic             go,
    output logic [CNT_W-1:0] reads,
    output tp_word_t         word,
    output logic             done
);

    phase_e           phase_q;
    rmw_cmd_t         cmd_q;
    tp_word_t         word_q;
    logic             go_q;
    logic [CNT_W-1:0] reads_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
            word_q  <= '0;
            go_q    <= 1'b0;
            reads_q <= '0;
            done_q  <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd;
                        word_q  <= read_word(cmd.adr);
                        reads_q <= CNT_W'(FETCH_READS);
                        go_q    <= 1'b1;
                        phase_q <= PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    if (fin) begin
                        word_q  <= data_word(cmd_q.adr,
                                             merge_bits(rd_low, cmd_q.mask, cmd_q.val));
                        reads_q <= CNT_W'(SETTLE_READS);
                        go_q    <= 1'b1;
                        phase_q <= PH_WR_LO;
                    end
                end
                PH_WR_LO: begin
                    if (fin) begin
                        word_q.we <= 1'b1;
                        go_q      <= 1'b1;
                        phase_q   <= PH_WR_HI;
                    end
                end
                PH_WR_HI: begin
                    if (fin) begin
                        word_q.we <= 1'b0;
                        go_q      <= 1'b1;
                        phase_q   <= PH_WR_END;
                    end
                end
                PH_WR_END: begin
                    if (fin) begin
                        word_q  <= read_word(cmd_q.adr);
                        reads_q <= CNT_W'(FETCH_READS);
                        go_q    <= 1'b1;
                        phase_q <= PH_CONFIRM;
                    end
                end
                PH_CONFIRM: begin
                    if (fin) begin
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign go    = go_q;
    assign reads = reads_q;
    assign word  = word_q;
    assign done  = done_q;

endmodule

// File: rtl/phy_tp_rmw.sv
module phy_tp_rmw
    import phy_tp_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DAT_W-1:0]  reg_mask,
    input  logic [DAT_W-1:0]  reg_value,
    output logic              done,
    output logic [WORD_W-1:0] tp_in,
    output logic              tp_rd_stb,
    input  logic [OUT_W-1:0]  tp_rd_data
);

    rmw_cmd_t         cmd;
    tp_word_t         word;
    logic             go;
    logic             fin;
    logic [CNT_W-1:0] reads;

    assign cmd.adr  = reg_addr;
    assign cmd.mask = reg_mask;
    assign cmd.val  = reg_value;

    generate
        if (OUT_W > DAT_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^tp_rd_data[OUT_W-1:DAT_W];
        end
    endgenerate

    phy_tp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmd    (cmd),
        .fin    (fin),
        .rd_low (tp_rd_data[DAT_W-1:0]),
        .go     (go),
        .reads  (reads),
        .word   (word),
        .done   (done)
    );

    phy_tp_pacer u_pacer (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .reads  (reads),
        .rd_stb (tp_rd_stb),
        .fin    (fin)
    );

    assign tp_in = word;

endmodule

// File: rtl/phy_tp_rmw_chk.sv
module phy_tp_rmw_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [13:0] tp_in,
    input logic        tp_rd_stb
);

    logic rst_q;

    // R10: one cycle after reset the outputs are quiet
    always_ff @(posedge clk) begin
        if (rst_q) begin
            p_reset_quiet_r10: assert (tp_in == 14'd0 && !done && !tp_rd_stb)
                else $error("R10 outputs not cleared after reset");
        end
        rst_q <= rst;
    end

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        tp_rd_stb |=> !tp_rd_stb);

    p_word_held_r4: assert property (@(posedge clk) disable iff (rst)
        tp_rd_stb |=> $stable(tp_in));

    p_we_toggle_same_fields_r5: assert property (@(posedge clk) disable iff (rst)
        (tp_in[0] != $past(tp_in[0])) |-> (tp_in[13:1] == $past(tp_in[13:1])));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !tp_rd_stb);

endmodule

bind phy_tp_rmw phy_tp_rmw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .tp_in     (tp_in),
    .tp_rd_stb (tp_rd_stb)
);

// File: tb/phy_tp_rmw_bench.sv
module phy_tp_rmw_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_mask = '0;
    logic [7:0]  reg_value = '0;
    logic        done;
    logic [13:0] tp_in;
    logic        tp_rd_stb;
    logic [31:0] tp_rd_data = '0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    phy_tp_rmw u_phy_tp_rmw (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .reg_addr   (reg_addr),
        .reg_mask   (reg_mask),
        .reg_value  (reg_value),
        .done       (done),
        .tp_in      (tp_in),
        .tp_rd_stb  (tp_rd_stb),
        .tp_rd_data (tp_rd_data)
    );

    // Behavioural PHY register file and observers (all on the falling edge)
    logic [7:0]  regs [32];
    logic [13:0] stb_log [16];
    logic        pend = 1'b0;
    logic [4:0]  pend_adr = '0;
    logic        prev_we = 1'b0;
    logic        prev_stb = 1'b0;
    int          stb_cnt = 0;
    int          done_cnt = 0;
    int          b2b = 0;
    int          cyc = 0;
    int          last_stb_cyc = 0;
    int          done_cyc = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            pend     = 1'b0;
            prev_we  = 1'b0;
            prev_stb = 1'b0;
            tp_rd_data = $urandom;
        end else begin
            if (pend) tp_rd_data = {$urandom(), regs[pend_adr]} >> 0;
            else      tp_rd_data = $urandom;
            if (pend) tp_rd_data[7:0] = regs[pend_adr];
            pend     = tp_rd_stb;
            pend_adr = tp_in[5:1];
            if (tp_rd_stb) begin
                if (stb_cnt < 16) stb_log[stb_cnt] = tp_in;
                stb_cnt      = stb_cnt + 1;
                last_stb_cyc = cyc;
                if (prev_stb) b2b = b2b + 1;
            end
            prev_stb = tp_rd_stb;
            if (tp_in[0] && !prev_we) regs[tp_in[5:1]] = tp_in[13:6];
            prev_we = tp_in[0];
            if (done) begin
                done_cnt = done_cnt + 1;
                done_cyc = cyc;
            end
        end
    end

    function automatic logic [13:0] mk_word(input logic [7:0] d, input logic [4:0] a,
                                            input logic we);
        return {d, a, we};
    endfunction

    function automatic logic [7:0] exp_merge(input logic [7:0] o, input logic [7:0] m,
                                             input logic [7:0] v);
        return (o & ~m) | (v & m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One command; poke_at > 0 pulses a rival start at that wait cycle (R9)
    task automatic run_rmw(input logic [4:0] a, input logic [7:0] m, input logic [7:0] v,
                           input int poke_at);
        logic [7:0]  old_v;
        logic [7:0]  new_v;
        logic [4:0]  rival;
        logic [7:0]  rival_old;
        logic [13:0] rw;
        logic [13:0] w0;
        logic [13:0] w1;
        bit          seq_ok;
        old_v     = regs[a];
        new_v     = exp_merge(old_v, m, v);
        rival     = a ^ 5'd1;
        rival_old = regs[rival];
        rw = mk_word(8'd1, a, 1'b0);
        w0 = mk_word(new_v, a, 1'b0);
        w1 = mk_word(new_v, a, 1'b1);
        stb_cnt  = 0;
        done_cnt = 0;
        b2b      = 0;
        @(negedge clk);
        start = 1'b1; reg_addr = a; reg_mask = m; reg_value = v;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < 200 && done_cnt == 0; i++) begin
            if (i == poke_at) begin
                start = 1'b1; reg_addr = rival; reg_mask = 8'hFF; reg_value = ~rival_old;
            end else begin
                start = 1'b0;
                reg_mask = $urandom; reg_value = $urandom;
            end
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(regs[a] == new_v, "R6", "merged register", regs[a], new_v);
        chk(stb_cnt == 12, "R3", "read count per command", stb_cnt, 12);
        chk(b2b == 0, "R4", "adjacent strobes", b2b, 0);
        seq_ok = (stb_log[0] == rw) && (stb_log[1] == rw) && (stb_log[2] == rw);
        chk(seq_ok, "R2", "fetch words", stb_log[2], rw);
        seq_ok = (stb_log[3] == w0) && (stb_log[4] == w0) && (stb_log[5] == w1) &&
                 (stb_log[6] == w1) && (stb_log[7] == w0) && (stb_log[8] == w0);
        chk(seq_ok, "R5", "write words R1 layout", stb_log[5], w1);
        seq_ok = (stb_log[9] == rw) && (stb_log[10] == rw) && (stb_log[11] == rw);
        chk(seq_ok, "R7", "confirm words", stb_log[11], rw);
        chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        chk(done_cyc == last_stb_cyc + 2, "R8", "done timing", done_cyc, last_stb_cyc + 2);
        if (poke_at > 0)
            chk(regs[rival] == rival_old, "R9", "rival register", regs[rival], rival_old);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(tp_in == 14'd0 && !done && !tp_rd_stb, "R10", "reset state",
            {tp_in, done, tp_rd_stb}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tp_rd_stb == 1'b0, "R8", "idle no strobe", tp_rd_stb, 0);

        // Directed corners
        run_rmw(5'd0,  8'h00, 8'hFF, 0);   // mask empty: unchanged
        run_rmw(5'd31, 8'hFF, 8'h3C, 0);   // full replace, top address
        run_rmw(5'd26, 8'hF0, 8'h50, 0);   // upper nibble
        run_rmw(5'd6,  8'h3F, 8'h00, 0);
        run_rmw(5'd12, 8'h08, 8'h08, 5);   // rival start during fetch
        run_rmw(5'd13, 8'hAA, 8'h55, 20);  // rival start during write

        // Reset in the middle of a fetch
        @(negedge clk);
        start = 1'b1; reg_addr = 5'd9; reg_mask = 8'hFF; reg_value = 8'h77;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(tp_in == 14'd0 && !done && !tp_rd_stb, "R10", "mid-command reset",
            {tp_in, done, tp_rd_stb}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Constrained random commands
        for (int n = 0; n < 40; n++) begin
            run_rmw(5'($urandom), 8'($urandom), 8'($urandom),
                    (n % 5 == 0) ? int'($urandom_range(3, 30)) : 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad   = bad + 1;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule